// File: doc/BRIEF.md
# Snooping Coherence Bus Arbiter

This block is the single shared broadcast point for a small group of cache controllers (four by default). A controller that needs a coherence action raises a request carrying an operation and a block address. These operations are a read miss, a write miss, or an invalidate for an upgrade from shared to modified. The request stays raised until the bus answers, so a write to shared data stalls until the controller has won the bus. The bus picks one requester at a time in round-robin order and holds the grant until that transaction ends. It drives the operation and address onto the broadcast lines for one cycle so that every other cache can compare the address against its tags. All coherence events pass through this one arbitration point, so every cache sees them in the same order. When two caches race for the same block, the loser sees the winner's broadcast first and has to refetch.

Each cache returns a snoop response (hit, dirty, and the block data) a fixed number of cycles after the broadcast. The bus starts a fixed-latency memory read together with the broadcast. At the snoop sampling cycle there are two cases. If another cache holds the block dirty, the bus aborts the memory read and takes the block from that cache. Otherwise it waits for memory. A one-cycle completion pulse then goes to the requester alone, with the data, a shared flag and a source flag. The bus then returns to idle and arbitrates again.

The controller has five states:
- IDLE: waits for a request and arbitrates.
- BCAST: drives the broadcast for one cycle and starts memory.
- SNOOP: counts to the sampling cycle.
- MEMWAIT: waits for memory data.
- DONE: drives the completion pulse.

The transitions are:
- IDLE goes to BCAST on any request.
- BCAST always goes to SNOOP.
- SNOOP goes to DONE at the sampling cycle for an invalidate or a dirty hit, and to MEMWAIT at that cycle otherwise.
- MEMWAIT goes to DONE when memory is ready.
- DONE always goes to IDLE.

Top module: `snoop_bus_arbiter`

## Requirements
- R1: During and after reset, until the first request, `grant`, `done`, `bc_valid` and `mem_abort` are all zero.
- R2: At most one `grant` bit is high at any time. It rises the cycle after the bus sees the request in idle, and it stays constant through the completion cycle. It is zero the cycle after completion, and a requester whose request is not yet granted stays stalled.
- R3: Arbitration is round-robin. After cache k is served, the search starts at cache k+1 and wraps around. After reset it starts at cache 0.
- R4: `bc_valid` is high for exactly one cycle: the first cycle of each grant. During that cycle `bc_op` and `bc_addr` carry the winner's operation and address. The operation codes are 0 = read miss, 1 = write miss, 2 = invalidate. Code 3 is reserved and is handled as an invalidate.
- R5: Snoop inputs are sampled only in the cycle that lies SNOOP_LAT cycles after the broadcast cycle. The requester's own hit and dirty bits are ignored.
- R6: A read or write miss with no dirty copy in another cache completes MEM_LAT+1 cycles after the broadcast cycle. Its data is the memory pattern, which is the zero-extended address XOR MEM_SEED. The source flag is 0.
- R7: A read or write miss with a dirty copy in another cache raises `mem_abort` for one cycle in the sampling cycle. It completes in the next cycle with the data of the lowest-index dirty cache and the source flag set to 1.
- R8: An invalidate starts no memory read and never raises `mem_abort`, even if a dirty response arrives. It completes in the cycle after sampling with data zero.
- R9: `done_shared` is 1 exactly when some cache other than the requester reported hit or dirty at the sampling cycle.
- R10: `done` is a one-cycle pulse on the requester's bit alone. The next grant can rise no earlier than two cycles after the completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_CACHE | Per-cache request, held until its done pulse |
| req_op | input | 2*N_CACHE | Per-cache operation code, 2 bits each |
| req_addr | input | N_CACHE*ADDR_W | Per-cache block address |
| snp_hit | input | N_CACHE | Per-cache snoop hit |
| snp_dirty | input | N_CACHE | Per-cache snoop dirty-owner flag |
| snp_data | input | N_CACHE*DATA_W | Per-cache block data offered on a dirty hit |
| grant | output | N_CACHE | One-hot bus owner, held for the whole transaction |
| bc_valid | output | 1 | Broadcast strobe |
| bc_op | output | 2 | Broadcast operation |
| bc_addr | output | ADDR_W | Broadcast block address |
| mem_abort | output | 1 | Cancels the memory read in flight |
| done | output | N_CACHE | Completion pulse to the requester |
| done_data | output | DATA_W | Block data returned with done |
| done_shared | output | 1 | Another cache holds a copy |
| done_from_cache | output | 1 | Data came from a dirty cache |

## Verification
Between sampling cycles the bench drives snoop responses with every hit and dirty bit set and with junk data. A bus that samples one cycle early or late would therefore abort memory on a clean miss or return junk. A requester that reports itself dirty checks the self-masking: a bus that fails to mask would abort its own memory read. An invalidate is given a stray dirty response, which catches a bus that aborts or returns data for an upgrade. Four simultaneous requests and a race of two invalidates to the same address check the round-robin order of completions. A bus that restarts from cache 0 or fails to hold the grant would serve the caches in the wrong order.

// File: rtl/snoop_bus_pkg.sv
package snoop_bus_pkg;

    typedef enum logic [1:0] {
        OP_RDMISS = 2'd0,
        OP_WRMISS = 2'd1,
        OP_INVAL  = 2'd2,
        OP_RSVD   = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BCAST,
        ST_SNOOP,
        ST_MEMWAIT,
        ST_DONE
    } bus_st_e;

    // Codes 2 and 3 both behave as an invalidate.
    function automatic logic op_is_inval(input logic [1:0] op);
        return op[1];
    endfunction

endpackage

// File: rtl/snoop_rr_arbiter.sv
module snoop_rr_arbiter #(
    parameter int N_REQ = 4,
    localparam int IDX_W = $clog2(N_REQ)
) (
    input  logic [N_REQ-1:0] req,
    input  logic [IDX_W-1:0] ptr,
    output logic [N_REQ-1:0] gnt_oh,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             gnt_any
);

    always_comb begin
        gnt_oh  = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int k = 0; k < N_REQ; k++) begin
            int cand;
            cand = (int'(ptr) + k) % N_REQ;
            if (!gnt_any && req[cand]) begin
                gnt_any       = 1'b1;
                gnt_idx       = IDX_W'(cand);
                gnt_oh[cand]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/snoop_resp_collect.sv
module snoop_resp_collect #(
    parameter int N_CACHE = 4,
    parameter int DATA_W  = 32
) (
    input  logic [N_CACHE-1:0]        hit,
    input  logic [N_CACHE-1:0]        dirty,
    input  logic [N_CACHE*DATA_W-1:0] data,
    input  logic [N_CACHE-1:0]        self_oh,
    output logic                      any_hit,
    output logic                      any_dirty,
    output logic [DATA_W-1:0]         owner_data
);

    logic [N_CACHE-1:0] other_hit;
    logic [N_CACHE-1:0] other_dirty;

    assign other_hit   = hit & ~self_oh;
    assign other_dirty = dirty & ~self_oh;
    assign any_hit     = |other_hit;
    assign any_dirty   = |other_dirty;

    // Lowest-index dirty snooper supplies the block.
    always_comb begin
        logic found;
        found      = 1'b0;
        owner_data = '0;
        for (int i = 0; i < N_CACHE; i++) begin
            if (!found && other_dirty[i]) begin
                found      = 1'b1;
                owner_data = data[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/snoop_mem_model.sv
module snoop_mem_model #(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 32,
    parameter int          MEM_LAT  = 6,
    parameter logic [31:0] MEM_SEED = 32'hA5A5_0000,
    localparam int         MCNT_W   = $clog2(MEM_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [ADDR_W-1:0] addr,
    output logic              rdy,
    output logic [DATA_W-1:0] data
);

    logic              busy_q;
    logic [MCNT_W-1:0] cnt_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            data_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= MCNT_W'(MEM_LAT - 1);
            data_q <= DATA_W'(addr) ^ DATA_W'(MEM_SEED);
        end else if (busy_q) begin
            if (abort || cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign rdy  = busy_q && (cnt_q == '0);
    assign data = data_q;

    // R7
    abort_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> busy_q);

    // R2
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);

endmodule

// File: rtl/snoop_bus_arbiter.sv
module snoop_bus_arbiter
    import snoop_bus_pkg::*;
#(
    parameter int          N_CACHE   = 4,
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 32,
    parameter int          SNOOP_LAT = 2,
    parameter int          MEM_LAT   = 6,
    parameter logic [31:0] MEM_SEED  = 32'hA5A5_0000,
    localparam int         IDX_W     = $clog2(N_CACHE),
    localparam int         SCNT_W    = $clog2(SNOOP_LAT + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CACHE-1:0]        req_valid,
    input  logic [2*N_CACHE-1:0]      req_op,
    input  logic [N_CACHE*ADDR_W-1:0] req_addr,
    input  logic [N_CACHE-1:0]        snp_hit,
    input  logic [N_CACHE-1:0]        snp_dirty,
    input  logic [N_CACHE*DATA_W-1:0] snp_data,
    output logic [N_CACHE-1:0]        grant,
    output logic                      bc_valid,
    output logic [1:0]                bc_op,
    output logic [ADDR_W-1:0]         bc_addr,
    output logic                      mem_abort,
    output logic [N_CACHE-1:0]        done,
    output logic [DATA_W-1:0]         done_data,
    output logic                      done_shared,
    output logic                      done_from_cache
);

    bus_st_e            state_q, state_d;
    logic [N_CACHE-1:0] grant_q;
    logic [IDX_W-1:0]   idx_q;
    logic [IDX_W-1:0]   ptr_q;
    logic [1:0]         op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [SCNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0]  dat_q;
    logic               shared_q;
    logic               fromc_q;

    logic [N_CACHE-1:0] arb_oh;
    logic [IDX_W-1:0]   arb_idx;
    logic               arb_any;
    logic               any_hit, any_dirty;
    logic [DATA_W-1:0]  owner_data;
    logic               mem_start, mem_rdy;
    logic [DATA_W-1:0]  mem_data;
    logic               sample;
    logic               is_inv;

    snoop_rr_arbiter #(.N_REQ(N_CACHE)) arb_i (
        .req     (req_valid),
        .ptr     (ptr_q),
        .gnt_oh  (arb_oh),
        .gnt_idx (arb_idx),
        .gnt_any (arb_any)
    );

    snoop_resp_collect #(.N_CACHE(N_CACHE), .DATA_W(DATA_W)) resp_i (
        .hit        (snp_hit),
        .dirty      (snp_dirty),
        .data       (snp_data),
        .self_oh    (grant_q),
        .any_hit    (any_hit),
        .any_dirty  (any_dirty),
        .owner_data (owner_data)
    );

    snoop_mem_model #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_LAT(MEM_LAT), .MEM_SEED(MEM_SEED)
    ) mem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mem_start),
        .abort (mem_abort),
        .addr  (addr_q),
        .rdy   (mem_rdy),
        .data  (mem_data)
    );

    assign is_inv = op_is_inval(op_q);
    assign sample = (state_q == ST_SNOOP) && (cnt_q == SCNT_W'(SNOOP_LAT - 1));

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (arb_any) state_d = ST_BCAST;
            ST_BCAST:   state_d = ST_SNOOP;
            ST_SNOOP:   if (sample) state_d = (is_inv || any_dirty) ? ST_DONE : ST_MEMWAIT;
            ST_MEMWAIT: if (mem_rdy) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            grant_q  <= '0;
            idx_q    <= '0;
            ptr_q    <= '0;
            op_q     <= '0;
            addr_q   <= '0;
            cnt_q    <= '0;
            dat_q    <= '0;
            shared_q <= 1'b0;
            fromc_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (arb_any) begin
                        grant_q  <= arb_oh;
                        idx_q    <= arb_idx;
                        op_q     <= req_op[2*arb_idx +: 2];
                        addr_q   <= req_addr[ADDR_W*arb_idx +: ADDR_W];
                        dat_q    <= '0;
                        shared_q <= 1'b0;
                        fromc_q  <= 1'b0;
                    end
                end
                ST_BCAST: cnt_q <= '0;
                ST_SNOOP: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (sample) begin
                        shared_q <= any_hit || any_dirty;
                        if (is_inv) begin
                            dat_q <= '0;
                        end else if (any_dirty) begin
                            dat_q   <= owner_data;
                            fromc_q <= 1'b1;
                        end
                    end
                end
                ST_MEMWAIT: if (mem_rdy) dat_q <= mem_data;
                ST_DONE: begin
                    grant_q <= '0;
                    ptr_q   <= (idx_q == IDX_W'(N_CACHE - 1)) ? '0 : idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        grant           = grant_q;
        bc_valid        = (state_q == ST_BCAST);
        bc_op           = op_q;
        bc_addr         = addr_q;
        mem_start       = (state_q == ST_BCAST) && !is_inv;
        mem_abort       = sample && any_dirty && !is_inv;
        done            = (state_q == ST_DONE) ? grant_q : '0;
        done_data       = dat_q;
        done_shared     = shared_q;
        done_from_cache = fromc_q;
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));

    // R2
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_q && !(|done)) |=> (grant_q == $past(grant_q)));

    // R4
    bcast_first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid |-> $rose(|grant_q));

    // R7
    abort_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_abort |=> (|done && done_from_cache));

    // R8
    inval_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|done && is_inv) |-> (done_data == '0 && !done_from_cache));

    // R10
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |done |=> (grant_q == '0 && !(|done)));

endmodule

// File: tb/snoop_bus_arbiter_tb_top.sv
module snoop_bus_arbiter_tb_top;

    localparam int          N    = 4;
    localparam int          AW   = 16;
    localparam int          DW   = 32;
    localparam int          SL   = 2;
    localparam int          ML   = 6;
    localparam logic [31:0] SEED = 32'hA5A5_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      req_valid = '0;
    logic [2*N-1:0]    req_op = '0;
    logic [N*AW-1:0]   req_addr = '0;
    logic [N-1:0]      snp_hit = '0;
    logic [N-1:0]      snp_dirty = '0;
    logic [N*DW-1:0]   snp_data = '0;
    logic [N-1:0]      grant;
    logic              bc_valid;
    logic [1:0]        bc_op;
    logic [AW-1:0]     bc_addr;
    logic              mem_abort;
    logic [N-1:0]      done;
    logic [DW-1:0]     done_data;
    logic              done_shared;
    logic              done_from_cache;

    snoop_bus_arbiter #(
        .N_CACHE(N), .ADDR_W(AW), .DATA_W(DW), .SNOOP_LAT(SL), .MEM_LAT(ML), .MEM_SEED(SEED)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .snp_hit(snp_hit), .snp_dirty(snp_dirty),
        .snp_data(snp_data), .grant(grant), .bc_valid(bc_valid), .bc_op(bc_op),
        .bc_addr(bc_addr), .mem_abort(mem_abort), .done(done),
        .done_data(done_data), .done_shared(done_shared),
        .done_from_cache(done_from_cache)
    );

    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // Snooper configuration for each possible requester.
    logic [N-1:0] cfg_hit [N];
    logic [N-1:0] cfg_dirty [N];

    function automatic logic [DW-1:0] cdata(input int i, input int a);
        return 32'hC000_0000 | (i << 16) | a;
    endfunction

    // Behavioural reference model.
    int cyc = 0;
    int m_busy = 0, m_w = 0, m_op = 0, m_addr = 0, m_t0 = 0, m_tdone = -1, m_ptr = 0;
    logic [DW-1:0] m_data = '0;
    logic m_shared = 1'b0, m_fromc = 1'b0;
    int order_q[$];
    int dut_order[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_ptr = 0; m_tdone = -1;
        end else if (m_busy == 0) begin
            for (int k = 0; k < N; k++) begin
                int c;
                c = (m_ptr + k) % N;
                if (m_busy == 0 && req_valid[c]) begin
                    m_busy = 1; m_w = c; m_op = int'(req_op[2*c +: 2]);
                    m_addr = int'(req_addr[AW*c +: AW]); m_t0 = cyc + 1; m_tdone = -1;
                end
            end
        end else begin
            if (cyc == m_t0 + SL) begin
                logic [N-1:0] oh, od;
                oh = snp_hit & ~(N'(1) << m_w);
                od = snp_dirty & ~(N'(1) << m_w);
                m_shared = |(oh | od);
                if (m_op >= 2) begin
                    m_data = '0; m_fromc = 1'b0; m_tdone = cyc + 1;
                end else if (od != '0) begin
                    int j;
                    j = -1;
                    for (int i = N - 1; i >= 0; i--) if (od[i]) j = i;
                    m_data = snp_data[DW*j +: DW]; m_fromc = 1'b1; m_tdone = cyc + 1;
                end else begin
                    m_data = DW'(m_addr) ^ SEED; m_fromc = 1'b0; m_tdone = m_t0 + ML + 1;
                end
            end
            if (cyc == m_tdone) begin
                m_busy = 0; m_ptr = (m_w + 1) % N;
            end
        end
        cyc = cyc + 1;
    end

    // Snoop responder: real values only in the sampling cycle, junk otherwise.
    always @(negedge clk) begin
        if (m_busy != 0 && cyc == m_t0 + SL) begin
            snp_hit   <= cfg_hit[m_w];
            snp_dirty <= cfg_dirty[m_w];
            for (int i = 0; i < N; i++) snp_data[DW*i +: DW] <= cdata(i, m_addr);
        end else begin
            snp_hit   <= '1;
            snp_dirty <= '1;
            for (int i = 0; i < N; i++) snp_data[DW*i +: DW] <= 32'hDEAD_0000 | i;
        end
        if (m_busy != 0 && cyc == m_tdone) req_valid[m_w] <= 1'b0;
    end

    // Cycle-by-cycle comparison, away from the clock edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            logic [N-1:0] eg, ed, od;
            logic eb, ea;
            eg = (m_busy != 0) ? (N'(1) << m_w) : '0;
            eb = (m_busy != 0) && (cyc == m_t0);
            od = snp_dirty & ~(N'(1) << m_w);
            ea = (m_busy != 0) && (cyc == m_t0 + SL) && (m_op < 2) && (od != '0);
            ed = ((m_busy != 0) && (cyc == m_tdone)) ? (N'(1) << m_w) : '0;
            chk("R2/R3", "grant", 32'(grant), 32'(eg));
            chk("R4", "bc_valid", 32'(bc_valid), 32'(eb));
            if (eb) begin
                chk("R4", "bc_op", 32'(bc_op), 32'(m_op));
                chk("R4", "bc_addr", 32'(bc_addr), 32'(m_addr));
            end
            chk("R5/R7/R8", "mem_abort", 32'(mem_abort), 32'(ea));
            chk("R10", "done", 32'(done), 32'(ed));
            if (ed != '0) begin
                chk("R6/R7/R8", "done_data", done_data, m_data);
                chk("R9", "done_shared", 32'(done_shared), 32'(m_shared));
                chk("R6/R7", "done_from_cache", 32'(done_from_cache), 32'(m_fromc));
            end
            if (done != '0) begin
                for (int i = 0; i < N; i++) if (done[i]) dut_order.push_back(i);
            end
        end
    end

    task automatic post(input int i, input int op, input int a, input logic [N-1:0] h, input logic [N-1:0] d);
        cfg_hit[i]   = h;
        cfg_dirty[i] = d;
        req_op[2*i +: 2]    <= 2'(op);
        req_addr[AW*i +: AW] <= AW'(a);
        req_valid[i]        <= 1'b1;
        order_q.push_back(-1);
        void'(order_q.pop_back());
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (req_valid != '0 || m_busy != 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            cfg_hit[i] = '0;
            cfg_dirty[i] = '0;
        end
        repeat (4) @(negedge clk);
        // R1: outputs idle in reset
        chk("R1", "grant in reset", 32'(grant), 0);
        chk("R1", "done in reset", 32'(done), 0);
        chk("R1", "bc_valid in reset", 32'(bc_valid), 0);
        chk("R1", "mem_abort in reset", 32'(mem_abort), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "grant after reset", 32'(grant), 0);

        // R6: clean read miss, no sharers
        @(negedge clk); post(0, 0, 16'h0100, 4'b0000, 4'b0000); wait_idle();
        // R9: clean read miss with a clean sharer
        @(negedge clk); post(1, 0, 16'h0204, 4'b1000, 4'b0000); wait_idle();
        // R7: read miss with dirty owner 0
        @(negedge clk); post(2, 0, 16'h0308, 4'b0001, 4'b0001); wait_idle();
        // R7: write miss, dirty owner 1 and another sharer
        @(negedge clk); post(3, 1, 16'h0410, 4'b0110, 4'b0010); wait_idle();
        // R8: invalidate with stray dirty response
        @(negedge clk); post(0, 2, 16'h0514, 4'b0110, 4'b1000); wait_idle();
        // R5: requester reports itself dirty; must be ignored
        @(negedge clk); post(1, 0, 16'h0618, 4'b0010, 4'b0010); wait_idle();
        // R3: four simultaneous requests
        @(negedge clk);
        post(0, 0, 16'h0700, 4'b0000, 4'b0000);
        post(1, 1, 16'h0704, 4'b0001, 4'b0001);
        post(2, 0, 16'h0708, 4'b0010, 4'b0000);
        post(3, 2, 16'h070C, 4'b0001, 4'b0000);
        wait_idle();
        // R2/R3: two invalidates race for one block
        @(negedge clk);
        post(1, 2, 16'h0800, 4'b1000, 4'b0000);
        post(3, 2, 16'h0800, 4'b0010, 4'b0000);
        wait_idle();
        // R4: reserved code handled as invalidate
        @(negedge clk); post(2, 3, 16'h0900, 4'b0001, 4'b0001); wait_idle();

        // R3: completion order over the whole run
        begin
            int exp_ord[13] = '{0, 1, 2, 3, 0, 1, 2, 3, 0, 1, 3, 1, 2};
            chk("R3", "completion count", 32'(dut_order.size()), 13);
            for (int i = 0; i < 13; i++) begin
                int a;
                a = (i < dut_order.size()) ? dut_order[i] : -1;
                chk("R3", "completion order", 32'(a), 32'(exp_ord[i]));
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule